// File: doc/BRIEF.md
# Indexed Vector Gather, Scatter and Merge Engine

This engine moves vector elements between an internal vector register file and a small external data memory, with addresses taken from the contents of an index register instead of a fixed stride. A gather fills a destination register from memory locations chosen by an index vector. A scatter writes a source register to memory locations chosen by an index vector. A merge compares two registers element by element and copies elements of a third register into the destination only where the comparison holds. A sequential load fills a register from consecutive memory words, so that index vectors and operands can be built up.

Commands arrive on a valid/ready port. `cmd_ready` is high only while the engine is idle, and that includes the cycle in which `done` pulses. All command fields are sampled at the clock edge where `cmd_valid` and `cmd_ready` are both high. While a command runs, `cmd_ready` stays low, and a held `cmd_valid` waits without any effect. The data memory side has no back-pressure. It is a single port with a fixed read latency of one clock: read data for an address issued in one cycle must be on `mem_rdata` in the next cycle. The engine processes one element per clock, in ascending element order, and the first element starts in the cycle after acceptance.

Top module: `vgsm_unit`

## Requirements
- R1: After reset `cmd_ready` is 1, and `done` and `mem_req` are 0. A command is accepted at an edge where `cmd_valid` and `cmd_ready` are both 1. After a command of nonzero length is accepted, `cmd_ready` is 0 until the engine is idle again.
- R2: Opcode 0 (gather) writes element i of register `cmd_vd` with the memory word at address (`cmd_base` + low address bits of element i of register `cmd_va`).
- R3: Opcode 1 (scatter) writes element i of register `cmd_vb` to memory at (`cmd_base` + low address bits of element i of register `cmd_va`). It changes no register.
- R4: When scatter addresses collide, the memory ends up holding the element with the highest element number, because writes go out in ascending element order.
- R5: Opcode 2 (merge) sets element i of `cmd_vd` to element i of `cmd_vc` where element i of `cmd_va` is greater than element i of `cmd_vb`. It leaves every other element of `cmd_vd` unchanged, including elements at or beyond the length, and it makes no memory access.
- R6: The merge comparison treats elements as signed two's-complement numbers, and equal elements do not copy.
- R7: Only the low `AW` bits of an index element are used, and the address sum wraps modulo the memory depth (2^`AW`).
- R8: A command of length L on a memory opcode makes exactly L consecutive memory accesses, one per clock. The first access is in the cycle right after acceptance, and there are no accesses while idle.
- R9: Gather and sequential load capture `mem_rdata` in the cycle after the address is issued.
- R10: Count the first cycle after the accepting edge as cycle 1. Then `done` is a one-cycle pulse in cycle L+2 for gather and sequential load (opcode 3, address `cmd_base` + i), and in cycle L+1 for scatter and merge.
- R11: A length of 0 makes no access and changes nothing, and `done` pulses in cycle 1. A length above `VLEN` is treated as `VLEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 gather, 1 scatter, 2 merge, 3 sequential load |
| cmd_vd | input | 3 | Destination register |
| cmd_va | input | 3 | Index register, or first compare operand for merge |
| cmd_vb | input | 3 | Scatter data register, or second compare operand |
| cmd_vc | input | 3 | Merge copy source register |
| cmd_base | input | AW (8) | Base address |
| cmd_len | input | 7 | Element count, saturated at VLEN |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (8) | Memory word address |
| mem_wdata | output | EW (64) | Write data |
| mem_rdata | input | EW (64) | Read data, one cycle after the address |
| done | output | 1 | Command completion pulse |

## Verification
The hardest case to reach is the state of the register file, because registers can only be seen by scattering them back out to memory. The bench therefore chains commands. It builds index and operand registers with sequential loads, then gathers or merges, then scatters the result under a distinct index vector, and a scoreboard compares each memory write in order. Colliding and wrapping addresses come from a short index register loaded with repeated values. The signed compare is exercised by negative and positive operands that would order the other way if read as unsigned.

// File: rtl/vgsm_pkg.sv
package vgsm_pkg;

  typedef enum logic [1:0] {
    OP_GATHER  = 2'd0,
    OP_SCATTER = 2'd1,
    OP_MERGE   = 2'd2,
    OP_SEQLOAD = 2'd3
  } vop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } vst_e;

  function automatic logic op_reads_mem(vop_e op);
    return (op == OP_GATHER) || (op == OP_SEQLOAD);
  endfunction

endpackage

// File: rtl/vgsm_regfile.sv
module vgsm_regfile #(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int EW   = 64,
  parameter int NRD  = 3,
  localparam int RW  = $clog2(NREG),
  localparam int LW  = $clog2(VLEN)
) (
  input  logic                     clk,
  input  logic [NRD-1:0][RW-1:0]   rd_reg,
  input  logic [NRD-1:0][LW-1:0]   rd_elem,
  output logic [NRD-1:0][EW-1:0]   rd_data,
  input  logic                     wr_en,
  input  logic [RW-1:0]            wr_reg,
  input  logic [LW-1:0]            wr_elem,
  input  logic [EW-1:0]            wr_data
);

  logic [EW-1:0] store [NREG][VLEN];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_reg][wr_elem] <= wr_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = store[rd_reg[g]][rd_elem[g]];
  end

endmodule

// File: rtl/vgsm_seq.sv
module vgsm_seq
  import vgsm_pkg::*;
#(
  parameter int NREG = 8,
  parameter int VLEN = 64,
  parameter int AW   = 8,
  localparam int RW  = $clog2(NREG),
  localparam int LW  = $clog2(VLEN),
  localparam int CW  = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_vd,
  input  logic [RW-1:0] cmd_va,
  input  logic [RW-1:0] cmd_vb,
  input  logic [RW-1:0] cmd_vc,
  input  logic [AW-1:0] cmd_base,
  input  logic [CW-1:0] cmd_len,
  output logic          issue,
  output vop_e          op,
  output logic [LW-1:0] elem,
  output logic [RW-1:0] vd,
  output logic [RW-1:0] va,
  output logic [RW-1:0] vb,
  output logic [RW-1:0] vc,
  output logic [AW-1:0] base,
  output logic          wb_valid,
  output logic [LW-1:0] wb_elem,
  output logic          done
);

  vst_e          state_q;
  logic [CW-1:0] cnt_q, len_q, len_eff;
  vop_e          op_q;
  logic [RW-1:0] vd_q, va_q, vb_q, vc_q;
  logic [AW-1:0] base_q;
  logic          wb_v_q, done_q;
  logic [LW-1:0] wb_elem_q;
  logic          accept, last;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign len_eff   = (cmd_len > CW'(VLEN)) ? CW'(VLEN) : cmd_len;
  assign last      = ((cnt_q + CW'(1)) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      op_q      <= OP_GATHER;
      vd_q      <= '0;
      va_q      <= '0;
      vb_q      <= '0;
      vc_q      <= '0;
      base_q    <= '0;
      wb_v_q    <= 1'b0;
      wb_elem_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      wb_v_q    <= (state_q == ST_RUN) && op_reads_mem(op_q);
      wb_elem_q <= cnt_q[LW-1:0];
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q   <= vop_e'(cmd_op);
            vd_q   <= cmd_vd;
            va_q   <= cmd_va;
            vb_q   <= cmd_vb;
            vc_q   <= cmd_vc;
            base_q <= cmd_base;
            len_q  <= len_eff;
            cnt_q  <= '0;
            if (len_eff == '0) done_q  <= 1'b1;
            else               state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (last) begin
            if (op_reads_mem(op_q)) begin
              state_q <= ST_DRAIN;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign issue    = (state_q == ST_RUN);
  assign op       = op_q;
  assign elem     = cnt_q[LW-1:0];
  assign vd       = vd_q;
  assign va       = va_q;
  assign vb       = vb_q;
  assign vc       = vc_q;
  assign base     = base_q;
  assign wb_valid = wb_v_q;
  assign wb_elem  = wb_elem_q;
  assign done     = done_q;

  // R1: a running command holds off the next one
  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (len_eff != '0) |=> !cmd_ready);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !accept |=> !done);

  // R11: the element counter never passes the vector length while running
  p_len_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (cnt_q < CW'(VLEN)));

endmodule

// File: rtl/vgsm_lane.sv
module vgsm_lane
  import vgsm_pkg::*;
#(
  parameter int EW         = 64,
  parameter int AW         = 8,
  parameter int LW         = 6,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  vop_e          op,
  input  logic [LW-1:0] elem,
  input  logic [AW-1:0] base,
  input  logic [EW-1:0] opa,
  input  logic [EW-1:0] opb,
  input  logic [EW-1:0] opc,
  input  logic          wb_valid,
  input  logic [LW-1:0] wb_elem,
  input  logic [EW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [EW-1:0] mem_wdata,
  output logic          rf_we,
  output logic [LW-1:0] rf_elem,
  output logic [EW-1:0] rf_wdata
);

  logic          gt;
  logic [AW-1:0] offset;
  logic          merge_active, merge_we;

  if (SIGNED_CMP) begin : g_cmp_s
    assign gt = $signed(opa) > $signed(opb);
  end else begin : g_cmp_u
    assign gt = opa > opb;
  end

  always_comb begin
    if (op == OP_SEQLOAD) offset = AW'(elem);
    else                  offset = opa[AW-1:0];
  end

  assign mem_addr     = base + offset;
  assign mem_req      = issue && (op != OP_MERGE);
  assign mem_we       = issue && (op == OP_SCATTER);
  assign mem_wdata    = opb;

  assign merge_active = issue && (op == OP_MERGE);
  assign merge_we     = merge_active && gt;

  assign rf_we    = wb_valid || merge_we;
  assign rf_elem  = wb_valid ? wb_elem : elem;
  assign rf_wdata = wb_valid ? mem_rdata : opc;

  // R9: load writeback never competes with a merge write
  p_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_valid, merge_active}));

endmodule

// File: rtl/vgsm_unit.sv
module vgsm_unit
  import vgsm_pkg::*;
#(
  parameter int NREG       = 8,
  parameter int VLEN       = 64,
  parameter int EW         = 64,
  parameter int AW         = 8,
  parameter bit SIGNED_CMP = 1'b1,
  localparam int RW        = $clog2(NREG),
  localparam int LW        = $clog2(VLEN),
  localparam int CW        = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [RW-1:0] cmd_vd,
  input  logic [RW-1:0] cmd_va,
  input  logic [RW-1:0] cmd_vb,
  input  logic [RW-1:0] cmd_vc,
  input  logic [AW-1:0] cmd_base,
  input  logic [CW-1:0] cmd_len,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [EW-1:0] mem_wdata,
  input  logic [EW-1:0] mem_rdata,
  output logic          done
);

  localparam int NRD = 3;

  logic          issue, wb_valid, rf_we;
  vop_e          op;
  logic [LW-1:0] elem, wb_elem, rf_elem;
  logic [RW-1:0] vd, va, vb, vc;
  logic [AW-1:0] base;
  logic [EW-1:0] rf_wdata;
  logic [NRD-1:0][RW-1:0] rd_reg;
  logic [NRD-1:0][LW-1:0] rd_elem;
  logic [NRD-1:0][EW-1:0] rd_data;

  vgsm_seq #(.NREG(NREG), .VLEN(VLEN), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_vd    (cmd_vd),
    .cmd_va    (cmd_va),
    .cmd_vb    (cmd_vb),
    .cmd_vc    (cmd_vc),
    .cmd_base  (cmd_base),
    .cmd_len   (cmd_len),
    .issue     (issue),
    .op        (op),
    .elem      (elem),
    .vd        (vd),
    .va        (va),
    .vb        (vb),
    .vc        (vc),
    .base      (base),
    .wb_valid  (wb_valid),
    .wb_elem   (wb_elem),
    .done      (done)
  );

  assign rd_reg[0] = va;
  assign rd_reg[1] = vb;
  assign rd_reg[2] = vc;
  for (genvar g = 0; g < NRD; g++) begin : g_elem
    assign rd_elem[g] = elem;
  end

  vgsm_regfile #(.NREG(NREG), .VLEN(VLEN), .EW(EW), .NRD(NRD)) u_rf (
    .clk     (clk),
    .rd_reg  (rd_reg),
    .rd_elem (rd_elem),
    .rd_data (rd_data),
    .wr_en   (rf_we),
    .wr_reg  (vd),
    .wr_elem (rf_elem),
    .wr_data (rf_wdata)
  );

  vgsm_lane #(.EW(EW), .AW(AW), .LW(LW), .SIGNED_CMP(SIGNED_CMP)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .op        (op),
    .elem      (elem),
    .base      (base),
    .opa       (rd_data[0]),
    .opb       (rd_data[1]),
    .opc       (rd_data[2]),
    .wb_valid  (wb_valid),
    .wb_elem   (wb_elem),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rf_we     (rf_we),
    .rf_elem   (rf_elem),
    .rf_wdata  (rf_wdata)
  );

  // R8: the memory port is quiet whenever the engine is idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);

  // R9: every memory read is followed by a register write in the next cycle
  p_load_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> rf_we);

  // R3: a scatter cycle never writes the register file
  p_scatter_noreg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !rf_we);

endmodule

// File: tb/vgsm_unit_tb.sv
module vgsm_unit_tb;

  localparam int NREG  = 8;
  localparam int VLEN  = 64;
  localparam int EW    = 64;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OPG = 2'd0, OPS = 2'd1, OPM = 2'd2, OPL = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [2:0]    cmd_vd = '0, cmd_va = '0, cmd_vb = '0, cmd_vc = '0;
  logic [AW-1:0] cmd_base = '0;
  logic [6:0]    cmd_len = '0;
  logic          mem_req, mem_we, done;
  logic [AW-1:0] mem_addr;
  logic [EW-1:0] mem_wdata;
  logic [EW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  vgsm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_vd(cmd_vd), .cmd_va(cmd_va), .cmd_vb(cmd_vb),
    .cmd_vc(cmd_vc), .cmd_base(cmd_base), .cmd_len(cmd_len),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
  );

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] rv  [NREG][VLEN];
  logic [AW+EW-1:0] exp_q [$];
  int    checks = 0, errors = 0, cyc = 0;
  int    acc_cyc, done_cyc, first_req, nreq;
  bit    done_seen;
  string cur_tag = "R3";

  // memory model: single port, one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [AW+EW-1:0] act, input logic [AW+EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard of memory writes, access count, done timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        if (nreq == 0) first_req = cyc;
        nreq++;
        if (mem_we) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, cur_tag, "unexpected write", {mem_addr, mem_wdata}, '0);
          end else begin
            logic [AW+EW-1:0] e;
            e = exp_q.pop_front();
            chk({mem_addr, mem_wdata} == e, cur_tag, "write addr/data",
                {mem_addr, mem_wdata}, e);
          end
        end
      end
      if (done && !done_seen) begin
        done_seen = 1'b1;
        done_cyc  = cyc;
      end
    end
  end

  task automatic run_cmd(input logic [1:0] op, input int vd, input int va,
                         input int vb, input int vc, input int base,
                         input int len, input string tag);
    int L, exp_done, exp_req;
    L = (len > VLEN) ? VLEN : len;
    cur_tag = tag;
    for (int i = 0; i < L; i++) begin
      case (op)
        OPL: rv[vd][i] = mem[AW'(base + i)];
        OPG: rv[vd][i] = mem[AW'(base + int'(rv[va][i][AW-1:0]))];
        OPS: exp_q.push_back({AW'(base + int'(rv[va][i][AW-1:0])), rv[vb][i]});
        default: if ($signed(rv[va][i]) > $signed(rv[vb][i])) rv[vd][i] = rv[vc][i];
      endcase
    end
    exp_done = (L == 0) ? 0 : ((op == OPG || op == OPL) ? L + 1 : L);
    exp_req  = (op == OPM) ? 0 : L;
    @(negedge clk);
    cmd_op = op; cmd_vd = 3'(vd); cmd_va = 3'(va); cmd_vb = 3'(vb);
    cmd_vc = 3'(vc); cmd_base = AW'(base); cmd_len = 7'(len);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    nreq = 0; done_seen = 1'b0; first_req = -1;
    @(posedge clk);
    #1 acc_cyc = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (L > 0) chk(cmd_ready == 1'b0, "R1", {tag, " ready while busy"}, 72'(cmd_ready), 0);
    while (!done_seen) @(negedge clk);
    chk(done_cyc - acc_cyc == exp_done, "R10", {tag, " done cycle"},
        72'(done_cyc - acc_cyc), 72'(exp_done));
    chk(nreq == exp_req, "R8", {tag, " access count"}, 72'(nreq), 72'(exp_req));
    if (exp_req > 0)
      chk(first_req == acc_cyc, "R8", {tag, " first access"}, 72'(first_req), 72'(acc_cyc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = {32'hC0DE_0000 | 32'(a), 32'(a * 7 + 3)};
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready in reset", 72'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", 72'(cmd_ready), 1);
    chk(done == 1'b0, "R1", "done after reset", 72'(done), 0);
    chk(mem_req == 1'b0, "R1", "req after reset", 72'(mem_req), 0);

    // index vector with garbage in the upper bits (R7 uses low bits only)
    for (int i = 0; i < VLEN; i++)
      mem[100 + i] = {56'(i * 1234567 + 99), 8'((i * 37 + 5) & 255)};
    run_cmd(OPL, 1, 0, 0, 0, 100, 64, "R10");
    // gather through wrapping addresses, then observe by scatter
    run_cmd(OPG, 2, 1, 0, 0, 200, 64, "R2");
    run_cmd(OPS, 0, 1, 2, 0, 0, 64, "R2");  // R9 R7 data path via scoreboard

    // merge operands: mixed signs, some equal pairs (R6)
    for (int i = 0; i < VLEN; i++) mem[i] = (i % 3 == 0) ? -64'(i + 1) : 64'(i * 5);
    run_cmd(OPL, 4, 0, 0, 0, 0, 64, "R10");
    for (int i = 0; i < VLEN; i++)
      mem[i] = (i % 7 == 0) ? rv[4][i] : ((i % 2 == 1) ? 64'd7 : -64'd3);
    run_cmd(OPL, 5, 0, 0, 0, 0, 64, "R10");
    for (int i = 0; i < VLEN; i++) mem[i] = {32'hCAFE_0000, 32'(i)};
    run_cmd(OPL, 6, 0, 0, 0, 0, 64, "R10");
    for (int i = 0; i < VLEN; i++) mem[i] = {32'h7777_0000, 32'(i)};
    run_cmd(OPL, 7, 0, 0, 0, 0, 64, "R10");
    run_cmd(OPM, 7, 4, 5, 6, 0, 40, "R5");
    run_cmd(OPS, 0, 1, 7, 0, 0, 64, "R6");  // R5 R6 result observed

    // colliding indices 7,7,3,7 (R4) and wrap past the top of memory (R7)
    mem[0] = 64'd7; mem[1] = 64'd7; mem[2] = 64'd3; mem[3] = 64'd7;
    run_cmd(OPL, 0, 0, 0, 0, 0, 4, "R10");
    run_cmd(OPS, 0, 0, 6, 0, 20, 4, "R4");
    @(negedge clk);
    chk(mem[27] == rv[6][3], "R4", "collision winner", 72'(mem[27]), 72'(rv[6][3]));
    chk(mem[23] == rv[6][2], "R4", "single write", 72'(mem[23]), 72'(rv[6][2]));
    run_cmd(OPS, 0, 0, 6, 0, 250, 4, "R7");
    @(negedge clk);
    chk(mem[1] == rv[6][3], "R7", "wrapped addr", 72'(mem[1]), 72'(rv[6][3]));
    chk(mem[253] == rv[6][2], "R7", "high addr", 72'(mem[253]), 72'(rv[6][2]));

    // zero length and oversized length (R11)
    run_cmd(OPG, 2, 1, 0, 0, 0, 0, "R11");
    run_cmd(OPM, 2, 4, 5, 6, 0, 0, "R11");
    run_cmd(OPS, 0, 1, 2, 0, 5, 100, "R11");  // also shows v2 untouched by zero-length ops

    @(negedge clk);
    chk(exp_q.size() == 0, "R3", "pending writes", 72'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule